// File: doc/BRIEF.md
# Parallel Halfword Saturating ALU

This block is a 64-bit packed arithmetic unit. Each operand is split into four 16-bit lanes, and every lane is computed on its own with no carry or borrow crossing into a neighbouring lane. It offers these operations:

- add and subtract with signed saturation;
- add and subtract with unsigned saturation, where the first operand is unsigned and the second is signed;
- an average whose lowest bit is sticky;
- shift-then-add, where the first operand is shifted left or right by 0 to 3 places before the add.

A caller presents two operands, a 3-bit operation code and a 2-bit shift amount together with `in_valid`. The result and `out_valid` appear one clock later. The result register holds its value in cycles with no request, so a downstream stage can read it at any later time.

Top module: `halfword_alu`

## Requirements
- R1: Lanes occupy result bits [15:0], [31:16], [47:32] and [63:48]. Each lane result depends only on the same lane of `opa` and `opb`.
- R2: Code 0 adds and code 2 subtracts (`opa - opb`). Both lanes are taken as signed, the exact result is formed, and it is clamped to -32768..32767 (0x8000..0x7FFF).
- R3: Code 1 adds and code 3 subtracts. The `opa` lane is taken as unsigned and the `opb` lane as signed, and the exact result is clamped to 0..65535.
- R4: Code 4 forms the 17-bit unsigned sum of both lanes. The result is the sum shifted right by one, with bit 0 then ORed with bit 0 of the sum.
- R5: Code 5 takes the signed `opa` lane, shifts it left by `shamt` (0..3), adds the signed `opb` lane and clamps the result to the signed 16-bit range.
- R6: Code 6 takes the signed `opa` lane, shifts it right arithmetically by `shamt`, adds the signed `opb` lane and clamps the result to the signed 16-bit range.
- R7: Code 7 gives an all-zero result.
- R8: A request with `in_valid` high produces its result and `out_valid` high exactly one cycle later. A cycle without a request gives `out_valid` low in the next cycle. Reset clears `result` and `out_valid`.
- R9: While `in_valid` is low, `result` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (see R2 to R7) |
| shamt | input | 2 | Shift amount for codes 5 and 6 |
| opa | input | 64 | First operand, four 16-bit lanes |
| opb | input | 64 | Second operand, four 16-bit lanes |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Registered lane results |

## Verification
The checker watches every cycle for the following properties:
- the one-cycle valid timing;
- the result holding while no request is present;
- the zero result of code 7;
- the sticky low bit of the average;
- the absence of wrap-around for a signed add of two non-negative lanes;
- the result never falling below the first operand for an unsigned add of a non-negative second lane.

The exact clamp values at both ends of each range, every shift amount, and the independence of the lanes when operands are mixed can only be shown by the bench. It compares each result against a lane model, first on directed corner operands and then on a long pseudo-random stream.

// File: rtl/halfword_alu.sv
module halfword_alu #(
  parameter int LANES = 4,
  parameter int LW    = 16,
  parameter int IW    = LW + 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [2:0]          op,
  input  logic [1:0]          shamt,
  input  logic [LANES*LW-1:0] opa,
  input  logic [LANES*LW-1:0] opb,
  output logic                out_valid,
  output logic [LANES*LW-1:0] result
);
  localparam int W = LANES * LW;
  localparam logic signed [IW-1:0] SMAX = IW'((1 << (LW - 1)) - 1);
  localparam logic signed [IW-1:0] SMIN = -IW'(1 << (LW - 1));
  localparam logic signed [IW-1:0] UMAX = IW'((1 << LW) - 1);

  logic [W-1:0] nxt;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [IW-1:0] sa, sb, ua, ub, sum;
    logic [LW-1:0] av;
    logic [LW-1:0] r;

    assign sa = {{(IW-LW){opa[LW*i+LW-1]}}, opa[LW*i +: LW]};
    assign sb = {{(IW-LW){opb[LW*i+LW-1]}}, opb[LW*i +: LW]};
    assign ua = {{(IW-LW){1'b0}}, opa[LW*i +: LW]};
    assign ub = {{(IW-LW){1'b0}}, opb[LW*i +: LW]};

    always_comb begin
      case (op)
        3'd0:    sum = sa + sb;
        3'd1:    sum = ua + sb;
        3'd2:    sum = sa - sb;
        3'd3:    sum = ua - sb;
        3'd4:    sum = ua + ub;
        3'd5:    sum = (sa <<< shamt) + sb;
        3'd6:    sum = (sa >>> shamt) + sb;
        default: sum = '0;
      endcase
    end

    assign av = sum[LW:1] | {{(LW-1){1'b0}}, sum[0]};

    always_comb begin
      if (op == 3'd1 || op == 3'd3)
        r = (sum < 0) ? '0 : (sum > UMAX) ? '1 : sum[LW-1:0];
      else if (op == 3'd4)
        r = av;
      else if (op == 3'd7)
        r = '0;
      else
        r = (sum > SMAX) ? SMAX[LW-1:0] : (sum < SMIN) ? SMIN[LW-1:0] : sum[LW-1:0];
    end

    assign nxt[LW*i +: LW] = r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= nxt;
    end
  end
endmodule

// File: rtl/halfword_alu_chk.sv
module halfword_alu_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  op,
  input logic [1:0]  shamt,
  input logic [63:0] opa,
  input logic [63:0] opb,
  input logic        out_valid,
  input logic [63:0] result
);
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r8_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  a_r7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd7) |=> (result == 64'd0));
  a_r4_sticky_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd4) |=>
      (result[0] == ($past(opa[1] ^ opb[1] ^ (opa[0] & opb[0])) | $past(opa[0] ^ opb[0]))));
  a_r2_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd0 && !opa[15] && !opb[15]) |=> !result[15]);
  a_r3_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd1 && !opb[15]) |=> (result[15:0] >= $past(opa[15:0])));
endmodule

bind halfword_alu halfword_alu_chk u_chk (.*);

// File: tb/tb_halfword_alu.sv
`timescale 1ns/1ps
module tb_halfword_alu;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [2:0] op = '0;
  logic [1:0] shamt = '0;
  logic [63:0] opa = '0, opb = '0;
  logic out_valid;
  logic [63:0] result;

  halfword_alu dut (.*);

  always #2.5 clk = ~clk;

  typedef struct { logic [63:0] exp; string tag; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [63:0] last = '0;

  function automatic logic [15:0] lane_ref(input logic [2:0] o, input logic [1:0] s,
                                           input logic [15:0] x, input logic [15:0] y);
    int sx = $signed(x), sy = $signed(y), ux = x, uy = y, v;
    case (o)
      3'd0, 3'd2, 3'd5, 3'd6: begin
        v = (o == 0) ? sx + sy : (o == 2) ? sx - sy : (o == 5) ? (sx << s) + sy : (sx >>> s) + sy;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return v[15:0];
      end
      3'd1, 3'd3: begin
        v = (o == 1) ? ux + sy : ux - sy;
        if (v > 65535) v = 65535;
        if (v < 0) v = 0;
        return v[15:0];
      end
      3'd4: begin
        v = ux + uy;
        return v[16:1] | {15'd0, v[0]};
      end
      default: return 16'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0, 3'd2: return "R2";
      3'd1, 3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [1:0] s,
                       input logic [63:0] x, input logic [63:0] y);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; op = o; shamt = s; opa = x; opb = y;
    for (int l = 0; l < 4; l++) it.exp[16*l +: 16] = lane_ref(o, s, x[16*l +: 16], y[16*l +: 16]);
    it.tag = tag_of(o);
    q.push_back(it);
    @(negedge clk);
    in_valid = 1'b0;
    opa = ~x; opb = ~y;
  endtask

  // monitor / scoreboard
  initial begin
    item_t it;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (out_valid) begin
        if (q.size() == 0) check("R8 unexpected valid", 64'd1, 64'd0);
        else begin
          it = q.pop_front();
          check({it.tag, " R1 R8"}, result, it.exp);
          last = it.exp;
        end
      end else begin
        check("R9 hold", result, last);
      end
    end
  end

  initial begin
    #50000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1;
    check("R8 reset valid", {63'd0, out_valid}, 64'd0);
    check("R8 reset result", result, 64'd0);
    #10 rst_n = 1'b1;
    // R2 corners
    issue(3'd0, 2'd0, 64'h7fff_8000_1234_0001, 64'h0001_ffff_edcc_0002);
    issue(3'd2, 2'd0, 64'h8000_7fff_0000_0005, 64'h0001_ffff_8000_0007);
    // R3 corners
    issue(3'd1, 2'd0, 64'hffff_0001_8000_0000, 64'h0001_fffe_8000_7fff);
    issue(3'd3, 2'd0, 64'h0000_ffff_0005_8000, 64'h0001_ffff_0007_8000);
    // R4 corners
    issue(3'd4, 2'd0, 64'h0001_ffff_0002_0000, 64'h0002_ffff_0003_0001);
    // R5 every shift
    for (int s = 0; s < 4; s++)
      issue(3'd5, 2'(s), 64'h4000_c000_0fff_f001, 64'h0001_ffff_7000_8000);
    // R6 every shift
    for (int s = 0; s < 4; s++)
      issue(3'd6, 2'(s), 64'h8000_7fff_fff9_0007, 64'h8000_7fff_0003_fffd);
    // R7
    issue(3'd7, 2'd3, 64'hffff_ffff_ffff_ffff, 64'h1234_5678_9abc_def0);
    // R1 lane independence: mixed saturating lanes
    issue(3'd0, 2'd0, 64'h7fff_0001_8000_0002, 64'h7fff_0001_8000_fffc);
    // back-to-back and random
    for (int n = 0; n < 300; n++) begin
      item_t it;
      logic [63:0] x = {$urandom, $urandom}, y = {$urandom, $urandom};
      logic [2:0] o = 3'($urandom);
      logic [1:0] s = 2'($urandom);
      @(negedge clk);
      in_valid = 1'b1; op = o; shamt = s; opa = x; opb = y;
      for (int l = 0; l < 4; l++) it.exp[16*l +: 16] = lane_ref(o, s, x[16*l +: 16], y[16*l +: 16]);
      it.tag = tag_of(o);
      q.push_back(it);
      if (n % 7 == 6) begin
        @(negedge clk);
        in_valid = 1'b0;
        opa = {$urandom, $urandom}; opb = {$urandom, $urandom}; op = 3'($urandom);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R8 queue drained", 64'(q.size()), 64'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule